// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Framed Serial Output

This block is the digital side of a successive-approximation analog-to-digital converter. A conversion request arrives on an input that has no fixed timing relation to the converter clock. The block synchronizes it and puts the track-and-hold into hold. It then runs a binary search with one trial code per serial-clock period. The trial code goes to an external DAC and comparator, and the comparator answer comes back as a single bit.

Each bit is sent on a framed serial port as soon as it is resolved, so the word goes out most significant bit first while the search is still running. The port has three open-drain lines: a serial clock, an active-low frame and a data line. Each output of the block tells whether its line is pulled low. A deasserted output means the line is released and an external pull-up reads it as high. A mode input chooses between a serial clock that always runs and one that toggles only while a word is framed.

The serial clock runs at half the block clock. The search stays aligned to it, so the time from a request to the first framed bit varies by one block clock, depending on where the request lands relative to the serial-clock phase.

Top module: `sar_serial_adc`

## Requirements
- R1: After synchronous reset, busy, hold, the frame pull-down and the data pull-down are all 0 and the trial code is 0.
- R2: A rising edge on the start input, once synchronized, raises busy and hold together at the SYNC_STAGES+1-th rising clock edge after the start rises. A start held high starts only one conversion.
- R3: Bits are resolved from MSB to LSB, each kept when the comparator reports 1 for the trial code that has that bit set. The word sent equals the largest code whose trial level is at or below the input, so every code from 0 to 2^WIDTH-1 can be produced.
- R4: If the comparator always answers 1 the result is all ones; if it always answers 0 the result is zero.
- R5: The frame line first goes low at rising clock edge SYNC_STAGES+4 or SYNC_STAGES+5 counted from the start's rise, which is two to three serial-clock periods after the synchronized request.
- R6: While the frame line is low there are exactly WIDTH falling edges of the serial clock, and the data line is stable at each of them. A pulled-low data line means bit value 0 and a released line means 1. The first bit sent is the MSB.
- R7: With the clock mode input at 1, the serial clock line toggles on every block clock cycle, including while idle.
- R8: With the clock mode input at 0, the serial clock line stays released whenever no word is framed, so each word has exactly WIDTH falling edges.
- R9: A start edge that arrives while busy is ignored: the current word is unchanged and no second frame follows.
- R10: Busy stays high for 2*WIDTH+3 or 2*WIDTH+4 block clock cycles and falls at the same clock edge that releases the frame line. Hold falls after the LSB is resolved and before busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_async | input | 1 | Asynchronous conversion request, rising edge starts |
| sclk_mode | input | 1 | 1: serial clock always runs; 0: clock only while framed |
| cmp_in | input | 1 | Comparator answer: 1 when input is at or above the trial level |
| trial_code | output | WIDTH | Trial code to the DAC; holds the final result after a conversion |
| hold | output | 1 | Track-and-hold control, 1 = hold |
| busy | output | 1 | Conversion or transmission in progress |
| sclk_pull_low | output | 1 | Serial clock line pulled low (0 = released) |
| frame_pull_low | output | 1 | Frame line pulled low, active frame (0 = released) |
| data_pull_low | output | 1 | Data line pulled low, bit 0 (0 = released) |

## Verification
The bench builds the block with WIDTH = 8 and the default two-stage synchronizer. At that width every one of the 256 output codes can be converted in both clock modes. Each code is driven once at an exact trial level and once half an LSB above it, and levels below zero and above full scale are added. The comparator model in the bench compares a doubled input level against the trial code, so every boundary between codes is hit from both sides. Some conversions get a second start pulse while busy, which exercises the ignore rule and the alignment variation in the start-to-frame delay.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Default configuration
    localparam int unsigned SAR_WIDTH_DEF = 12;
    localparam int unsigned SAR_SYNC_DEF  = 2;

    // Controller sequencing
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // tracking, waiting for a request
        ST_ALIGN = 2'd1,   // holding, waiting for a serial-clock boundary
        ST_CONV  = 2'd2,   // one trial per serial-clock period
        ST_TAIL  = 2'd3    // LSB on the line, search finished
    } sar_state_e;

    // Open-drain pull-down enables of the serial port
    typedef struct packed {
        logic sclk;
        logic frame;
        logic data;
    } od_pins_t;

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign rise_pulse = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/sar_search.sv
module sar_search
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_pulse,
    input  logic             tick,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] code,
    output logic             hold,
    output logic             busy,
    output logic             bit_strobe,
    output logic             bit_val,
    output logic             word_end
);
    localparam int unsigned IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

    sar_state_e       state_q;
    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] code_nxt;
    logic [IDXW-1:0]  idx_q;

    // Decide the current bit and set the next trial bit
    always_comb begin
        for (int b = 0; b < WIDTH; b++) begin
            if (b == int'(idx_q))          code_nxt[b] = cmp_in;
            else if (b + 1 == int'(idx_q)) code_nxt[b] = 1'b1;
            else                           code_nxt[b] = code_q[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_pulse) state_q <= ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (tick) begin
                        state_q <= ST_CONV;
                        code_q  <= {1'b1, {(WIDTH-1){1'b0}}};
                        idx_q   <= TOP_IDX;
                    end
                end
                ST_CONV: begin
                    if (tick) begin
                        code_q <= code_nxt;
                        if (idx_q == '0) state_q <= ST_TAIL;
                        else             idx_q   <= idx_q - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (tick) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign code       = code_q;
    assign hold       = (state_q == ST_ALIGN) || (state_q == ST_CONV);
    assign busy       = (state_q != ST_IDLE);
    assign bit_strobe = (state_q == ST_CONV) && tick;
    assign bit_val    = cmp_in;
    assign word_end   = (state_q == ST_TAIL) && tick;

endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_mode,
    input  logic     bit_strobe,
    input  logic     bit_val,
    input  logic     word_end,
    output logic     tick,
    output od_pins_t pins
);
    logic phase_q;
    logic frame_q;
    logic data_q;

    // Serial clock level: released (high) while phase_q is 1
    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    // A tick edge is one where the serial clock line rises
    assign tick = ~phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
            data_q  <= 1'b0;
        end else begin
            if (bit_strobe) begin
                frame_q <= 1'b1;
                data_q  <= bit_val;
            end else if (word_end) begin
                frame_q <= 1'b0;
            end
        end
    end

    always_comb begin
        pins.sclk  = ~phase_q & (sclk_mode | frame_q);
        pins.frame = frame_q;
        pins.data  = frame_q & ~data_q;
    end

endmodule

// File: rtl/sar_serial_adc.sv
module sar_serial_adc
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH       = SAR_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = SAR_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start_async,
    input  logic             sclk_mode,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] trial_code,
    output logic             hold,
    output logic             busy,
    output logic             sclk_pull_low,
    output logic             frame_pull_low,
    output logic             data_pull_low
);
    logic     start_pulse;
    logic     tick;
    logic     bit_strobe;
    logic     bit_val;
    logic     word_end;
    logic     busy_int;
    od_pins_t pins;

    sar_start_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst        (rst),
        .async_in   (conv_start_async),
        .rise_pulse (start_pulse)
    );

    // Requests are accepted only when idle
    sar_search #(.WIDTH(WIDTH)) search_i (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse & ~busy_int),
        .tick        (tick),
        .cmp_in      (cmp_in),
        .code        (trial_code),
        .hold        (hold),
        .busy        (busy_int),
        .bit_strobe  (bit_strobe),
        .bit_val     (bit_val),
        .word_end    (word_end)
    );

    sar_serial_port port_i (
        .clk        (clk),
        .rst        (rst),
        .sclk_mode  (sclk_mode),
        .bit_strobe (bit_strobe),
        .bit_val    (bit_val),
        .word_end   (word_end),
        .tick       (tick),
        .pins       (pins)
    );

    assign busy           = busy_int;
    assign sclk_pull_low  = pins.sclk;
    assign frame_pull_low = pins.frame;
    assign data_pull_low  = pins.data;

endmodule

// File: rtl/sar_serial_adc_chk.sv
module sar_serial_adc_chk (
    input logic clk,
    input logic rst,
    input logic sclk_mode,
    input logic hold,
    input logic busy,
    input logic sclk_pull_low,
    input logic frame_pull_low,
    input logic data_pull_low
);
    // R6: a frame exists only inside a busy interval
    a_r6_frame_in_busy: assert property (@(posedge clk) disable iff (rst)
        frame_pull_low |-> busy);

    // R6: data is driven only inside a frame
    a_r6_data_in_frame: assert property (@(posedge clk) disable iff (rst)
        data_pull_low |-> frame_pull_low);

    // R6: data and frame do not move while the serial clock is low
    a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
        sclk_pull_low |-> $stable(data_pull_low));
    a_r6_frame_steady: assert property (@(posedge clk) disable iff (rst)
        sclk_pull_low |-> $stable(frame_pull_low));

    // R8: gated clock stays released while idle
    a_r8_gated_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sclk_mode && !busy) |-> !sclk_pull_low);

    // R2: hold starts together with busy
    a_r2_hold_with_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> hold);

    // R10: hold never outlives busy; busy ends with the frame released
    a_r10_hold_in_busy: assert property (@(posedge clk) disable iff (rst)
        hold |-> busy);
    a_r10_end_released: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !frame_pull_low);

endmodule

bind sar_serial_adc sar_serial_adc_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .sclk_mode      (sclk_mode),
    .hold           (hold),
    .busy           (busy),
    .sclk_pull_low  (sclk_pull_low),
    .frame_pull_low (frame_pull_low),
    .data_pull_low  (data_pull_low)
);

// File: tb/sar_serial_adc_tb_top.sv
`timescale 1ns/1ps
module sar_serial_adc_tb_top;
    localparam int W    = 8;
    localparam int FULL = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    int           vin_x2 = 0;
    logic         cmp;
    logic [W-1:0] trial;
    logic         hold, busy, sp, fp, dp;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Comparator model: input level (in half LSBs) against trial level
    assign cmp = (vin_x2 >= 2 * int'(trial));

    sar_serial_adc #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .conv_start_async (start),
        .sclk_mode        (mode),
        .cmp_in           (cmp),
        .trial_code       (trial),
        .hold             (hold),
        .busy             (busy),
        .sclk_pull_low    (sp),
        .frame_pull_low   (fp),
        .data_pull_low    (dp)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic run_conv(input int level_x2, input bit m, input bit repulse);
        int  expv, got, nfall, frames, frame_first, busy_cnt, first_busy_n, quiet;
        bit  prev_s, prev_f, s, f, hold_first, hold_last;
        expv = level_x2 / 2;
        if (level_x2 < 0) expv = 0;
        if (expv > FULL) expv = FULL;
        got = 0; nfall = 0; frames = 0; frame_first = -1;
        busy_cnt = 0; first_busy_n = -1; hold_first = 0; hold_last = 1;
        mode = m;
        vin_x2 = level_x2;
        @(negedge clk);
        prev_s = !sp;
        prev_f = !fp;
        start = 1'b1;
        for (int k = 0; k < 80; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (repulse && k + 1 == 10) start = 1'b0;
            if (repulse && k + 1 == 14) start = 1'b1;
            s = !sp;
            f = !fp;
            if (busy) begin
                busy_cnt++;
                hold_last = hold;
                if (busy_cnt == 1) begin
                    first_busy_n = k + 1;
                    hold_first = hold;
                end
            end
            if (prev_f && !f) begin
                frames++;
                if (frame_first < 0) frame_first = k + 1;
            end
            if (prev_s && !s && !f) begin
                got = (got << 1) | (dp ? 0 : 1);
                nfall++;
            end
            prev_s = s;
            prev_f = f;
            if (busy_cnt > 0 && !busy) break;
        end
        check(got == expv, "R3/R4 result word", got, expv);
        check(nfall == W, "R6/R8 falling edges in frame", nfall, W);
        check(frames == 1, "R9 single frame", frames, 1);
        check(first_busy_n == 3, "R2 busy rise edge", first_busy_n, 3);
        check(hold_first == 1'b1, "R2 hold with busy", int'(hold_first), 1);
        check(frame_first == 6 || frame_first == 7, "R5 frame start edge", frame_first, 6);
        check(busy_cnt == 2*W+3 || busy_cnt == 2*W+4, "R10 busy length", busy_cnt, 2*W+3);
        check(hold_last == 1'b0, "R10 hold drops before busy", int'(hold_last), 0);
        // Start still high: no new conversion (R2, R9)
        quiet = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy || !fp == 1'b0) quiet++;
        end
        check(quiet == 0, "R9 no retrigger while start held", quiet, 0);
        start = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int toggles, lows;
        bit prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(hold == 1'b0, "R1 hold", int'(hold), 0);
        check(fp == 1'b0, "R1 frame released", int'(fp), 0);
        check(dp == 1'b0, "R1 data released", int'(dp), 0);
        check(trial == '0, "R1 trial code", int'(trial), 0);

        // R7 continuous clock toggles while idle
        mode = 1'b1;
        @(negedge clk);
        prev = !sp;
        toggles = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if ((!sp) != prev) toggles++;
            prev = !sp;
        end
        check(toggles == 10, "R7 idle clock toggles", toggles, 10);

        // R8 gated clock released while idle
        mode = 1'b0;
        @(negedge clk);
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sp) lows++;
        end
        check(lows == 0, "R8 idle clock released", lows, 0);

        // R3 every code at exact level and half an LSB above, both modes
        for (int c = 0; c <= FULL; c++) begin
            run_conv(2*c,     c[0],  1'b0);
            run_conv(2*c + 1, !c[0], (c % 17) == 0);
        end

        // R4 out-of-range levels
        run_conv(2*(FULL + 40), 1'b1, 1'b0);
        run_conv(-5,            1'b0, 1'b0);
        run_conv(2*(FULL + 40), 1'b0, 1'b1);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule